// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

This block is a bank of five PWM timers behind a 32-bit register bus. Each timer has a count buffer and a compare buffer. An active down-counter and an active compare value sit behind them, and a single PWM output comes out of each timer. Software writes the buffers and then pulses a per-channel update bit, which copies the buffers into the active state. It then sets the run and reload bits. The counter steps down once per shared prescaled tick. When a period ends, it either reloads from the buffers or parks at zero, and it raises a sticky per-channel event flag that can be routed to one interrupt line.

The channel controls share one 32-bit control word. Channel 0 sits at bit 0. Every other channel n starts at bit 4(n+1). Within a field the bits are, from its base: run, update, invert, auto-reload, dead-zone flag. Because the fields are only four bits apart, the dead-zone flag of channels 1 to 3 aliases the run bit of the next channel. The dead-zone flag is stored but has no effect. The live counters can be read at observation addresses. Because channel 4's formula address would collide with the interrupt register at 0x44, channel 4's observation address is moved to 0x48.

Top module: `pwm_timer_bank`

## Requirements
- R1: Registers read back what was written: configuration A at 0x00 (32 bits), configuration B at 0x04 (32 bits, no effect), count buffer n at 0x0C+12n and compare buffer n at 0x10+12n (low CNT_W bits kept, upper bits read 0), control word at 0x08 with only the field bits (0..4, 8..24) kept, so an all-ones write reads back 0x01FFFF1F.
- R2: The control field of channel n has its base at bit 0 for n=0 and at bit 4(n+1) otherwise. Relative to that base, bit 0 is run, bit 1 is update, bit 2 is invert and bit 3 is auto-reload.
- R3: While a channel's update bit is 1, its counter is loaded from the count buffer and its active compare value from the compare buffer, and a parked channel becomes live again.
- R4: A running, live channel with run=1 decrements its counter on each tick. At the tick where the counter is 0 with auto-reload set, it reloads both buffers, so a count buffer of N−1 gives an N-tick period.
- R5: The uninverted output of a live channel is high exactly when its counter is at or below the active compare value.
- R6: Setting the invert bit inverts that channel's output.
- R7: With auto-reload clear, the channel keeps counting to the end of the current period, then parks at count 0 with its uninverted output low until the next update.
- R8: The low 8 bits of configuration A set a tick every (value+1) clock cycles, shared by all channels.
- R9: At 0x44, bits 0..4 are per-channel interrupt enables and bits 5..9 are per-channel period-end flags. A flag is set at each period end and cleared by writing 1 to it. `irq` is high while any enabled flag is set.
- R10: Counter observation addresses (0x14+12n for n=0..3, 0x48 for channel 4) return the live counter, and writes to them change nothing.
- R11: After reset, every register reads 0, all counters are parked at 0, all outputs are low and `irq` is low.
- R12: With run=0 and update=0, a channel's counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 5 | One PWM output per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check several rules on every cycle. An update loads the count buffer. A period end with auto-reload set reloads the counter. A period end with reload clear leaves the counter at zero, and a parked or stopped counter stays still. Period-end flags stay set until cleared, and a prescaler with a nonzero divisor never ticks on two adjacent cycles. Other behaviours only the bench scenarios can show. These are the exact count and output sequence for each channel and compare value, the field positions in the control word, the measured tick rate, the graceful stop with inversion, the interrupt enable and clear path, and read-only observation.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int NCH = 5;
    localparam int AW  = 8;
    localparam int FLD = 5;

    localparam logic [AW-1:0] A_CFGA = 8'h00;
    localparam logic [AW-1:0] A_CFGB = 8'h04;
    localparam logic [AW-1:0] A_CTL  = 8'h08;
    localparam logic [AW-1:0] A_IRQ  = 8'h44;

    // per-channel control field, lsb first: run, update, invert, reload, dead-zone
    typedef struct packed {
        logic dz;
        logic reload;
        logic inv;
        logic upd;
        logic run;
    } ch_ctl_t;

    function automatic int ctl_base(input int n);
        return (n == 0) ? 0 : 4 * (n + 1);
    endfunction

    function automatic logic [AW-1:0] cnt_addr(input int n);
        return AW'(8'h0C + 12 * n);
    endfunction

    function automatic logic [AW-1:0] cmp_addr(input int n);
        return AW'(8'h10 + 12 * n);
    endfunction

    // the last channel's observation slot would land on A_IRQ, so it moves up
    function automatic logic [AW-1:0] obs_addr(input int n);
        return (n == NCH - 1) ? AW'(8'h48) : AW'(8'h14 + 12 * n);
    endfunction

    function automatic logic [31:0] ctl_mask_f();
        logic [31:0] m;
        m = '0;
        for (int n = 0; n < NCH; n++) begin
            m = m | (32'h1F << ctl_base(n));
        end
        return m;
    endfunction

    localparam logic [31:0] CTL_MASK = ctl_mask_f();

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;

    assign tick = (pcnt >= div);

    always_ff @(posedge clk) begin
        if (rst)       pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
    end

    // R8: a nonzero divisor never yields ticks on adjacent cycles
    a_r8_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  ch_ctl_t          ctl,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] count,
    output logic             pwm_out,
    output logic             period_end
);
    logic [CNT_W-1:0] cmp_act;
    logic             parked;
    logic             step;
    logic             level;

    assign step       = tick && ctl.run && !parked && !ctl.upd;
    assign period_end = step && (count == '0);
    assign level      = !parked && (count <= cmp_act);
    assign pwm_out    = level ^ ctl.inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            cmp_act <= '0;
            parked  <= 1'b1;
        end else if (ctl.upd) begin
            count   <= cnt_buf;
            cmp_act <= cmp_buf;
            parked  <= 1'b0;
        end else if (step) begin
            if (count != '0) begin
                count <= count - 1'b1;
            end else if (ctl.reload) begin
                count   <= cnt_buf;
                cmp_act <= cmp_buf;
            end else begin
                parked <= 1'b1;
            end
        end
    end

    // R3: update copies the count buffer
    a_r3_update_load: assert property (@(posedge clk) disable iff (rst)
        ctl.upd |=> (count == $past(cnt_buf)));

    // R4: reload at period end
    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        (period_end && ctl.reload) |=> (count == $past(cnt_buf)));

    // R7: stop at end of period when reload is clear
    a_r7_park_zero: assert property (@(posedge clk) disable iff (rst)
        (period_end && !ctl.reload) |=> (count == '0 && !level));

    a_r7_parked_still: assert property (@(posedge clk) disable iff (rst)
        (parked && !ctl.upd) |=> $stable(count));

    // R12: run cleared holds the counter
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !ctl.upd) |=> $stable(count));

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic [NCH-1:0] pwm_out,
    output logic          irq
);
    logic [31:0]      cfga_q, cfgb_q, ctl_q;
    logic [CNT_W-1:0] cnt_buf [NCH];
    logic [CNT_W-1:0] cmp_buf [NCH];
    logic [CNT_W-1:0] live    [NCH];
    logic [NCH-1:0]   irq_en, irq_st, pend;
    ch_ctl_t          ch_ctl  [NCH];
    logic             tick;
    logic             irq_wr;

    assign irq_wr = reg_we && (reg_addr == A_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfga_q <= '0;
            cfgb_q <= '0;
            ctl_q  <= '0;
            irq_en <= '0;
            irq_st <= '0;
            for (int n = 0; n < NCH; n++) begin
                cnt_buf[n] <= '0;
                cmp_buf[n] <= '0;
            end
        end else begin
            if (reg_we && reg_addr == A_CFGA) cfga_q <= reg_wdata;
            if (reg_we && reg_addr == A_CFGB) cfgb_q <= reg_wdata;
            if (reg_we && reg_addr == A_CTL)  ctl_q  <= reg_wdata & CTL_MASK;
            for (int n = 0; n < NCH; n++) begin
                if (reg_we && reg_addr == cnt_addr(n)) cnt_buf[n] <= reg_wdata[CNT_W-1:0];
                if (reg_we && reg_addr == cmp_addr(n)) cmp_buf[n] <= reg_wdata[CNT_W-1:0];
            end
            if (irq_wr) begin
                irq_en <= reg_wdata[NCH-1:0];
                irq_st <= (irq_st & ~reg_wdata[2*NCH-1:NCH]) | pend;
            end else begin
                irq_st <= irq_st | pend;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CFGA) reg_rdata = cfga_q;
        if (reg_addr == A_CFGB) reg_rdata = cfgb_q;
        if (reg_addr == A_CTL)  reg_rdata = ctl_q;
        if (reg_addr == A_IRQ)  reg_rdata = 32'({irq_st, irq_en});
        for (int n = 0; n < NCH; n++) begin
            if (reg_addr == cnt_addr(n)) reg_rdata = 32'(cnt_buf[n]);
            if (reg_addr == cmp_addr(n)) reg_rdata = 32'(cmp_buf[n]);
            if (reg_addr == obs_addr(n)) reg_rdata = 32'(live[n]);
        end
    end

    assign irq = |(irq_en & irq_st);

    pwmt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .div  (cfga_q[PRE_W-1:0]),
        .tick (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_ctl[g] = ctl_q[ctl_base(g) +: FLD];

        pwmt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .ctl        (ch_ctl[g]),
            .cnt_buf    (cnt_buf[g]),
            .cmp_buf    (cmp_buf[g]),
            .count      (live[g]),
            .pwm_out    (pwm_out[g]),
            .period_end (pend[g])
        );
    end

    // R9: flags stay set until a write-one clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        !irq_wr |=> ((irq_st & $past(irq_st)) == $past(irq_st)));

    // R9: every period end leaves its flag set
    a_r9_set: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |=> ((irq_st & $past(pend)) == $past(pend)));

endmodule

// File: tb/sim_pwm_timer_bank.sv
module sim_pwm_timer_bank;
    import pwmt_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  pwm_out;
    logic        irq;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    pwm_timer_bank u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
    );

    function automatic int fbase(int n);
        return (n == 0) ? 0 : 4 * (n + 1);
    endfunction
    function automatic logic [7:0] a_cnt(int n); return 8'(12 + 12 * n); endfunction
    function automatic logic [7:0] a_cmp(int n); return 8'(16 + 12 * n); endfunction
    function automatic logic [7:0] a_obs(int n); return (n == 4) ? 8'h48 : 8'(20 + 12 * n); endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // load buffers, pulse update, then run; returns with counter == cnt
    task automatic start_ch(input int n, input int cnt, input int cmp, input bit rl, input bit inv);
        wr(a_cnt(n), 32'(cnt));
        wr(a_cmp(n), 32'(cmp));
        wr(8'h08, (32'(2 | (inv ? 4 : 0))) << fbase(n));
        wr(8'h08, (32'(1 | (inv ? 4 : 0) | (rl ? 8 : 0))) << fbase(n));
    endtask

    initial begin
        logic [31:0] v, prev;
        int changes;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();

        // R11: reset state
        rd(8'h00, v); chk("R11 cfgA", v, 0);
        rd(8'h08, v); chk("R11 ctl", v, 0);
        rd(8'h44, v); chk("R11 irq reg", v, 0);
        for (int n = 0; n < 5; n++) begin
            rd(a_cnt(n), v); chk("R11 cnt buf", v, 0);
            rd(a_obs(n), v); chk("R11 live", v, 0);
        end
        chk("R11 outputs", 32'(pwm_out), 0);
        chk("R11 irq", 32'(irq), 0);

        // R2 R3 R4 R5: sweep of every channel and compare value, period 4
        for (int n = 0; n < 5; n++) begin
            for (int c = 0; c < 4; c++) begin
                start_ch(n, 3, c, 1'b1, 1'b0);
                for (int k = 0; k < 9; k++) begin
                    int ec;
                    ec = 3 - (k % 4);
                    rd(a_obs(n), v); chk("R4 count sequence", v, 32'(ec));
                    chk("R5 output level", 32'(pwm_out[n]), 32'(ec <= c));
                    step();
                end
            end
        end

        // R1: readback
        wr(8'h04, 32'hA5A55A5A); rd(8'h04, v); chk("R1 cfgB", v, 32'hA5A55A5A);
        wr(a_cnt(2), 32'h12345); rd(a_cnt(2), v); chk("R1 cnt buf width", v, 32'h2345);
        wr(a_cmp(4), 32'h0000BEEF); rd(a_cmp(4), v); chk("R1 ch4 cmp", v, 32'hBEEF);
        wr(8'h08, 32'hFFFFFFFF); rd(8'h08, v); chk("R1 ctl mask", v, 32'h01FFFF1F);
        wr(8'h08, 32'h0);

        // R12: stopped counter holds; R10: observation is read-only
        rd(a_obs(2), prev); chk("R3 load via update", prev, 32'h2345);
        repeat (5) step();
        rd(a_obs(2), v); chk("R12 hold", v, prev);
        wr(a_obs(2), 32'h7);
        rd(a_obs(2), v); chk("R10 write ignored", v, prev);
        rd(a_cnt(2), v); chk("R10 buffer untouched", v, 32'h2345);

        // R9: one-shot on channel 1 sets its flag, enable routes to irq
        wr(8'h44, 32'h3E0);
        start_ch(1, 3, 1, 1'b0, 1'b0);
        repeat (8) step();
        rd(a_obs(1), v); chk("R7 parked at 0", v, 0);
        chk("R7 output low", 32'(pwm_out[1]), 0);
        rd(8'h44, v); chk("R9 flag set", v, 32'h40);
        chk("R9 irq masked", 32'(irq), 0);
        repeat (4) step();
        rd(a_obs(1), v); chk("R7 stays parked", v, 0);
        wr(8'h44, 32'h02);
        chk("R9 irq enabled", 32'(irq), 1);
        rd(8'h44, v); chk("R9 reg", v, 32'h42);
        wr(8'h44, 32'h42);
        chk("R9 irq cleared", 32'(irq), 0);
        rd(8'h44, v); chk("R9 w1c", v, 32'h02);

        // R6 R7: inverted channel 2, reload removed mid-period
        start_ch(2, 9, 2, 1'b1, 1'b1);
        step(); step();
        rd(a_obs(2), v); chk("R6 count", v, 7);
        chk("R6 inverted output", 32'(pwm_out[2]), 1);
        wr(8'h08, 32'h5 << fbase(2));
        rd(a_obs(2), prev);
        chk("R7 still counting", 32'(prev != 0), 1);
        step();
        rd(a_obs(2), v); chk("R7 decrement after reload off", v, prev - 1);
        repeat (12) step();
        rd(a_obs(2), v); chk("R7 stop at end", v, 0);
        chk("R7 inactive inverted", 32'(pwm_out[2]), 1);

        // R8: divisor 2 gives 10 ticks over 30 cycles
        wr(8'h00, 32'h2);
        rd(8'h00, v); chk("R1 cfgA", v, 2);
        start_ch(0, 3, 0, 1'b1, 1'b0);
        changes = 0;
        rd(a_obs(0), prev);
        for (int k = 0; k < 30; k++) begin
            step();
            rd(a_obs(0), v);
            if (v != prev) changes++;
            prev = v;
        end
        chk("R8 tick rate", 32'(changes), 10);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule